// File: doc/BRIEF.md
# FIFO Service Interrupt Generator

This block raises the host service interrupt for a small parallel-port FIFO. It watches the FIFO fill count, the transfer direction and the host control bits. It raises an interrupt in four cases. In programmed I/O, the FIFO reaches its service threshold in the current direction. In DMA mode, a terminal count arrives. The fault line falls while fault interrupts are enabled. The acknowledge line rises while acknowledge interrupts are enabled.

The interrupt line can be shared with other sources. For a fixed number of clocks it is driven low, and the pad enable `irq_oe` is high for the same clocks. After that the line returns to high impedance, so other sources on the same wire can pull it.

The threshold is the programmed 4-bit code plus one. In the write direction it is compared with the free space, and in the read direction with the bytes held.

Top module: `fifo_svc_irq`

## Requirements
- R1: Each accepted event drives `irq_oe` high and `irq_n` low for exactly PULSE_CYC clocks (2 by default), starting with the clock after the edge that sampled the event. At all other times `irq_oe` is low and `irq_n` is high impedance.
- R2: A clock with `tc_strobe`=1, `dma_on`=1 and `svc_hold`=0 is an event. A terminal count with `svc_hold`=1 or `dma_on`=0 is not an event.
- R3: With `dma_on`=0, `svc_hold`=0 and `dir_rd`=0 (write direction), an event occurs on the clock where DEPTH − `fill_cnt` first becomes at least the threshold.
- R4: With `dma_on`=0, `svc_hold`=0 and `dir_rd`=1 (read direction), an event occurs on the clock where `fill_cnt` first becomes at least the threshold.
- R5: If the threshold condition already holds, changing `svc_hold` from 1 to 0 with `dma_on`=0 is an event.
- R6: A threshold condition that stays true raises no further event. While `svc_hold`=1 or `dma_on`=1, threshold conditions raise no event.
- R7: With `fault_mask_n`=0, a fall of `fault_n` is an event. Changing `fault_mask_n` from 1 to 0 while `fault_n` is 0 is also an event. While `fault_mask_n`=1, `fault_n` changes raise nothing.
- R8: With `ack_en`=1, a rise of `ack_n` is an event. A fall of `ack_n`, or any change of `ack_n` while `ack_en`=0, raises nothing.
- R9: The threshold equals `thr_code`+1, so the codes 0 to 15 give thresholds 1 to 16.
- R10: An event sampled while a pulse is running is merged into that pulse. It neither lengthens the pulse nor starts a second one.
- R11: While `rst_n` is low (synchronous reset), `irq_oe` is low from the next clock on. Input levels present when reset is released do not count as edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_cnt | input | CNT_W (5) | Bytes currently held in the FIFO, 0..DEPTH |
| dir_rd | input | 1 | Direction: 1 = host reads from the FIFO, 0 = host writes |
| dma_on | input | 1 | DMA mode enable |
| svc_hold | input | 1 | Service-pending bit; 1 blocks threshold and terminal-count events |
| thr_code | input | THR_W (4) | Programmed threshold minus one |
| tc_strobe | input | 1 | DMA terminal-count strobe |
| fault_n | input | 1 | Fault line, active low |
| fault_mask_n | input | 1 | Fault interrupt enable, active low |
| ack_n | input | 1 | Acknowledge line |
| ack_en | input | 1 | Acknowledge interrupt enable |
| irq_oe | output | 1 | Pad drive enable for the shared interrupt line |
| irq_n | output | 1 | Shared interrupt line: 0 while pulsing, otherwise high impedance |

## Verification
The bench builds the block with its defaults: a 16-byte FIFO, a 4-bit threshold code and a 2-clock pulse. With these values both ends of the threshold range can be reached. Code 15 needs an empty FIFO for a write-direction event. Code 0 fires in the read direction on the first byte. A 2-clock pulse is short enough that two events on consecutive clocks land inside one pulse, which exercises the merge rule. Each stimulus sequence also changes direction, mode and enable bits, so the events these changes cause are checked against the model.

// File: rtl/fsi_pkg.sv
package fsi_pkg;

  // Threshold test: read direction compares held bytes,
  // write direction compares free space, against code+1.
  function automatic logic thr_met(input int depth, input int fill,
                                   input int code, input logic rd);
    int thr;
    thr = code + 1;
    if (rd) return fill >= thr;
    return (depth - fill) >= thr;
  endfunction

endpackage

// File: rtl/fsi_rise_det.sv
module fsi_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  // During reset the history tracks the input, so a level held at
  // release is not taken as an edge.
  always_ff @(posedge clk) begin
    lvl_q <= lvl;
  end

  assign rise = rst_n & lvl & ~lvl_q;
endmodule

// File: rtl/fsi_level_mon.sv
module fsi_level_mon #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic             dir_rd,
  input  logic             dma_on,
  input  logic             svc_hold,
  input  logic [THR_W-1:0] thr_code,
  output logic             pio_req,
  output logic             pio_ev
);
  import fsi_pkg::*;

  logic level_ok;

  always_comb begin
    level_ok = thr_met(DEPTH, int'(fill_cnt), int'(thr_code), dir_rd);
    pio_req  = level_ok & ~dma_on & ~svc_hold;
  end

  fsi_rise_det u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (pio_req),
    .rise (pio_ev)
  );
endmodule

// File: rtl/fsi_pulse.sv
module fsi_pulse #(
  parameter int PULSE_CYC = 2,
  localparam int PW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  output logic start,
  output logic busy
);
  logic [PW-1:0] left_q;

  assign busy  = left_q != '0;
  assign start = ev & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n)     left_q <= '0;
    else if (busy)  left_q <= left_q - 1'b1;
    else if (start) left_q <= PW'(PULSE_CYC);
  end
endmodule

// File: rtl/fifo_svc_irq.sv
module fifo_svc_irq #(
  parameter int DEPTH     = 16,
  parameter int THR_W     = 4,
  parameter int PULSE_CYC = 2,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic             dir_rd,
  input  logic             dma_on,
  input  logic             svc_hold,
  input  logic [THR_W-1:0] thr_code,
  input  logic             tc_strobe,
  input  logic             fault_n,
  input  logic             fault_mask_n,
  input  logic             ack_n,
  input  logic             ack_en,
  output logic             irq_oe,
  output wire              irq_n
);
  logic pio_req, pio_ev;
  logic dma_ev;
  logic fault_arm, fault_ev;
  logic ack_rise, ack_ev;
  logic ev_any, pulse_start;

  fsi_level_mon #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .fill_cnt(fill_cnt),
    .dir_rd  (dir_rd),
    .dma_on  (dma_on),
    .svc_hold(svc_hold),
    .thr_code(thr_code),
    .pio_req (pio_req),
    .pio_ev  (pio_ev)
  );

  assign dma_ev    = tc_strobe & dma_on & ~svc_hold;
  assign fault_arm = ~fault_mask_n & ~fault_n;

  fsi_rise_det u_fault (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (fault_arm),
    .rise (fault_ev)
  );

  fsi_rise_det u_ack (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (ack_n),
    .rise (ack_rise)
  );

  assign ack_ev = ack_rise & ack_en;
  assign ev_any = rst_n & (pio_ev | dma_ev | fault_ev | ack_ev);

  fsi_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .ev   (ev_any),
    .start(pulse_start),
    .busy (irq_oe)
  );

  assign irq_n = irq_oe ? 1'b0 : 1'bz;
endmodule

// File: rtl/fifo_svc_irq_chk.sv
module fifo_svc_irq_chk #(
  parameter int PULSE_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic irq_oe,
  input logic ev_any,
  input logic pulse_start,
  input logic dma_ev,
  input logic fault_ev,
  input logic pio_ev,
  input logic dma_on,
  input logic svc_hold
);
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_len <= 0;
    else if (irq_oe) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  assert_pulse_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start |=> irq_oe);

  assert_pulse_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> run_len < PULSE_CYC);

  assert_pulse_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_len > 0 && run_len < PULSE_CYC) |-> irq_oe);

  assert_tc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ev && !irq_oe) |=> irq_oe);

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_any && !irq_oe) |=> !irq_oe);

  assert_pio_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on || svc_hold) |-> !pio_ev);

  assert_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev && !irq_oe) |=> irq_oe);

  assert_reset_R11: assert property (@(posedge clk)
    !rst_n |=> !irq_oe);
endmodule

bind fifo_svc_irq fifo_svc_irq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_oe     (irq_oe),
  .ev_any     (ev_any),
  .pulse_start(pulse_start),
  .dma_ev     (dma_ev),
  .fault_ev   (fault_ev),
  .pio_ev     (pio_ev),
  .dma_on     (dma_on),
  .svc_hold   (svc_hold)
);

// File: tb/tb_fifo_svc_irq.sv
module tb_fifo_svc_irq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int PULSE = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] fill_cnt;
  logic       dir_rd, dma_on, svc_hold, tc_strobe;
  logic [3:0] thr_code;
  logic       fault_n, fault_mask_n, ack_n, ack_en;
  logic       irq_oe;
  wire        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R11";

  fifo_svc_irq dut (
    .clk(clk), .rst_n(rst_n), .fill_cnt(fill_cnt), .dir_rd(dir_rd),
    .dma_on(dma_on), .svc_hold(svc_hold), .thr_code(thr_code),
    .tc_strobe(tc_strobe), .fault_n(fault_n), .fault_mask_n(fault_mask_n),
    .ack_n(ack_n), .ack_en(ack_en), .irq_oe(irq_oe), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: remembered levels and a countdown integer.
  int  m_left = 0;
  bit  m_pio_prev, m_fault_prev, m_ack_prev;
  bit  m_pio_now, m_fault_now, m_ev;

  function automatic bit level_hit(int fill, int code, bit rd);
    if (rd) return fill > code;
    return DEPTH - fill > code;
  endfunction

  always @(posedge clk) begin
    m_pio_now   = level_hit(fill_cnt, thr_code, dir_rd) && !dma_on && !svc_hold;
    m_fault_now = !fault_mask_n && !fault_n;
    if (!rst_n) begin
      m_left = 0;
    end else begin
      m_ev = (m_pio_now && !m_pio_prev)
          || (tc_strobe && dma_on && !svc_hold)
          || (m_fault_now && !m_fault_prev)
          || (ack_en && ack_n && !m_ack_prev);
      if (m_left > 0) m_left = m_left - 1;
      else if (m_ev)  m_left = PULSE;
    end
    m_pio_prev   = m_pio_now;
    m_fault_prev = m_fault_now;
    m_ack_prev   = ack_n;
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (irq_oe !== (m_left > 0)) begin
        errors++;
        $display("FAIL %s: irq_oe actual %0b expected %0b at %0t",
                 cur_req, irq_oe, m_left > 0, $time);
      end
      if (m_left > 0) begin
        checks++;
        if (irq_n !== 1'b0) begin
          errors++;
          $display("FAIL R1: irq_n actual %b expected 0 at %0t", irq_n, $time);
        end
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; fill_cnt = 16; dir_rd = 0; dma_on = 0; svc_hold = 1;
    thr_code = 7; tc_strobe = 0; fault_n = 0; fault_mask_n = 0;
    ack_n = 1; ack_en = 1;
    // R11: fault armed and ack high during reset must not fire on release
    cur_req = "R11"; step(3);
    rst_n = 1; step(4);
    fault_n = 1; step(2);

    // R3: write direction, threshold 8 free bytes
    cur_req = "R3"; svc_hold = 0; step(2);
    fill_cnt = 9; step(2);
    fill_cnt = 8; step(4);
    // R6: condition held, more free space, no retrigger
    cur_req = "R6"; fill_cnt = 2; step(5);
    svc_hold = 1; fill_cnt = 16; step(2); fill_cnt = 0; step(3);
    dma_on = 1; svc_hold = 0; fill_cnt = 16; step(2); fill_cnt = 0; step(3);
    // R5: leaving hold while condition met (via dma_on 0 first keep hold)
    cur_req = "R5"; svc_hold = 1; dma_on = 0; step(2);
    svc_hold = 0; step(4);

    // R4: read direction, threshold 4 bytes
    cur_req = "R4"; svc_hold = 1; dir_rd = 1; thr_code = 3; fill_cnt = 0; step(2);
    svc_hold = 0; step(2);
    fill_cnt = 3; step(2); fill_cnt = 4; step(4); fill_cnt = 10; step(3);

    // R9: code 15 needs 16 free; code 0 fires at one byte
    cur_req = "R9"; svc_hold = 1; dir_rd = 0; thr_code = 15; fill_cnt = 1; step(2);
    svc_hold = 0; step(3); fill_cnt = 0; step(4);
    svc_hold = 1; dir_rd = 1; thr_code = 0; fill_cnt = 0; step(2);
    svc_hold = 0; step(3); fill_cnt = 1; step(4);

    // R2: terminal count in DMA mode
    cur_req = "R2"; dma_on = 1; svc_hold = 0; step(3);
    tc_strobe = 1; step(1); tc_strobe = 0; step(4);
    svc_hold = 1; tc_strobe = 1; step(1); tc_strobe = 0; step(3);
    dma_on = 0; tc_strobe = 1; step(1); tc_strobe = 0; step(3);

    // R7: fault edges and enable change
    cur_req = "R7"; fault_mask_n = 0; fault_n = 1; step(3);
    fault_n = 0; step(4); fault_n = 1; step(2);
    fault_mask_n = 1; fault_n = 0; step(3); fault_n = 1; step(2); fault_n = 0; step(2);
    fault_mask_n = 0; step(4);
    fault_n = 1; step(2);

    // R8: ack rise with and without enable, falls ignored
    cur_req = "R8"; ack_en = 1; ack_n = 0; step(3); ack_n = 1; step(4);
    ack_en = 0; ack_n = 0; step(2); ack_n = 1; step(3);

    // R10: ack rise then fault fall one clock later: one pulse only
    cur_req = "R10"; ack_en = 1; ack_n = 0; step(3);
    ack_n = 1; step(1); fault_n = 0; step(5);
    fault_n = 1; step(1);
    // event on the last pulse cycle is also merged
    ack_n = 0; step(1); ack_n = 1; step(2); tc_strobe = 1; dma_on = 1; step(1);
    tc_strobe = 0; dma_on = 0; step(4);

    // R1: single pulse length checked after a lone event
    cur_req = "R1"; ack_n = 0; step(2); ack_n = 1; step(1);
    step(1); step(1); step(3);

    // R11: reset in the middle of a pulse
    cur_req = "R11"; ack_n = 0; step(2); ack_n = 1; step(1);
    rst_n = 0; step(3); rst_n = 1; step(3);

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule